// File: doc/BRIEF.md
# Sleep and Power-On Reset Sequencer

This block sequences reset and the two low-power states of a small 8-bit controller core. It drives three things: the enable of the gated CPU clock, the enable of the main oscillator and the core reset. Its inputs are a power-good level, a watchdog timeout pulse, single-cycle HALT and STOP requests from the core, interrupt pulses and a bank of wake-capable pins. Power coming good, a watchdog timeout and (optionally) recovery from STOP start a one-shot counter that holds the core in reset for a fixed number of clock cycles. The default of 589,824 cycles gives about 147 ms at 4 MHz.

In HALT only the CPU clock stops, and any interrupt resumes execution. In STOP the oscillator is also disabled. Only a reset or a falling edge on a wake pin ends STOP. The pins pass through a two-flop synchroniser and a falling-edge detector clocked by the free-running reference `clk_i`. A status byte reports whether the last wake was from STOP (bit 6, cleared on read) and whether the last reset came from the watchdog (bit 5). A separate output tells the core whether to restart at its fixed recovery address or at the vector of the interrupt pin that woke it.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, or one cycle after `pwr_good_i` is sampled low, the outputs are: `core_rst_o`=1, `cpu_clk_en_o`=0, `osc_en_o`=1, `stat_o`=0 and `resume_irq_o`=0.
- R2: With `pwr_good_i` high, `core_rst_o` stays high for exactly `POR_CYCLES` rising edges after reset release or after power goes good. The block then runs with `cpu_clk_en_o`=1.
- R3: A `wdt_timeout_i` pulse with power good does the following in any state: it restarts the full one-shot, sets `stat_o[5]` and clears `stat_o[6]` and `resume_irq_o`. Only a power failure or `rst_ni` clears `stat_o[5]`.
- R4: In run, a `halt_req_i` pulse gives `cpu_clk_en_o`=0 with `osc_en_o`=1 from the next cycle.
- R5: In HALT, any bit of `irq_i` gives `cpu_clk_en_o`=1 in the next cycle.
- R6: In run, a `stop_req_i` pulse gives `cpu_clk_en_o`=0 and `osc_en_o`=0 from the next cycle. When both requests arrive in the same cycle, STOP takes priority over HALT.
- R7: In STOP, `irq_i`, `halt_req_i` and `stop_req_i` have no effect. A wake pin that falls is acted on at the third rising edge after the change.
- R8: On a STOP wake with `skip_smr_por_i`=0, the block runs the full `POR_CYCLES` one-shot. With `skip_smr_por_i`=1 it goes straight to run, with `cpu_clk_en_o`=1 and `core_rst_o`=0.
- R9: A STOP wake sets `stat_o[6]`. A `stat_rd_i` pulse clears it in the next cycle, and a wake in the same cycle wins over the read.
- R10: At a STOP wake, `resume_irq_o` becomes 1 when any falling pin is set in `IRQ_PIN_MASK` (default: pins 0 to 3), and 0 otherwise.
- R11: While the one-shot is counting, `halt_req_i` and `stop_req_i` are ignored.
- R12: Rising edges on wake pins, and falling edges outside STOP, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply good level |
| wdt_timeout_i | input | 1 | Watchdog timeout pulse |
| halt_req_i | input | 1 | HALT request pulse from core |
| stop_req_i | input | 1 | STOP request pulse from core |
| irq_i | input | N_IRQ | Interrupt pulses (external and timer) |
| wake_pin_i | input | N_WAKE | Asynchronous wake-capable pins, idle high |
| skip_smr_por_i | input | 1 | Skip the one-shot after STOP recovery |
| stat_rd_i | input | 1 | Status read strobe |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Core reset |
| stat_o | output | 8 | Status: bit 6 stop wake, bit 5 watchdog reset |
| resume_irq_o | output | 1 | 1: restart at interrupt vector, 0: fixed address |

## Verification
Directed sequences cover the following cases:
- wake from a non-interrupt pin, and wake from an interrupt pin, which tells the two restart targets apart;
- wake with and without the skip option, which separates the long and short recovery paths;
- requests issued during the one-shot;
- a read that clears the stop flag.

Random stimulus then mixes request pulses, interrupts, pin toggles, reads, watchdog pulses and short power dips. A cycle model in the bench follows the same stream, so every output is compared in every cycle. This exposes wrong priorities between simultaneous events and wrong synchroniser latency.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_RESET = 2'd0,
    PS_RUN   = 2'd1,
    PS_HALT  = 2'd2,
    PS_STOP  = 2'd3
  } pstate_e;

  localparam int STAT_STOP_BIT = 6;
  localparam int STAT_WDT_BIT  = 5;
endpackage

// File: rtl/por_oneshot.sv
module por_oneshot #(
  parameter int CYCLES = 589824
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign fall_o[g] = prev_q & ~s2_q;
  end
endmodule

// File: rtl/wake_status.sv
module wake_status #(
  parameter int           N    = 11,
  parameter logic [N-1:0] MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         por_clr_i,
  input  logic         wdt_set_i,
  input  logic         wake_i,
  input  logic [N-1:0] fall_i,
  input  logic         rd_i,
  output logic         stop_flag_o,
  output logic         wdt_flag_o,
  output logic         resume_irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_flag_o  <= 1'b0;
      wdt_flag_o   <= 1'b0;
      resume_irq_o <= 1'b0;
    end else if (por_clr_i) begin
      stop_flag_o  <= 1'b0;
      wdt_flag_o   <= 1'b0;
      resume_irq_o <= 1'b0;
    end else if (wdt_set_i) begin
      stop_flag_o  <= 1'b0;
      wdt_flag_o   <= 1'b1;
      resume_irq_o <= 1'b0;
    end else if (wake_i) begin
      stop_flag_o  <= 1'b1;
      resume_irq_o <= |(fall_i & MASK);
    end else if (rd_i) begin
      stop_flag_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int                POR_CYCLES   = 589824,
  parameter int                N_IRQ        = 6,
  parameter int                N_WAKE       = 11,
  parameter logic [N_WAKE-1:0] IRQ_PIN_MASK = N_WAKE'(4'hF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              wdt_timeout_i,
  input  logic              halt_req_i,
  input  logic              stop_req_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_WAKE-1:0] wake_pin_i,
  input  logic              skip_smr_por_i,
  input  logic              stat_rd_i,
  output logic              cpu_clk_en_o,
  output logic              osc_en_o,
  output logic              core_rst_o,
  output logic [7:0]        stat_o,
  output logic              resume_irq_o
);
  import pwr_seq_pkg::*;

  pstate_e           state_q, state_d;
  logic [N_WAKE-1:0] wake_fall;
  logic              por_clr, wdt_hit, wake_ev, os_done, os_clr;
  logic              stop_flag, wdt_flag;

  assign por_clr = ~pwr_good_i;
  assign wdt_hit = pwr_good_i & wdt_timeout_i;
  assign wake_ev = (state_q == PS_STOP) & (|wake_fall) & ~por_clr & ~wdt_hit;
  assign os_clr  = (state_q != PS_RESET) | por_clr | wdt_hit;

  wake_edge_det #(.N(N_WAKE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (wake_pin_i),
    .fall_o (wake_fall)
  );

  por_oneshot #(.CYCLES(POR_CYCLES)) u_oneshot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (os_clr),
    .done_o (os_done)
  );

  wake_status #(.N(N_WAKE), .MASK(IRQ_PIN_MASK)) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_clr_i    (por_clr),
    .wdt_set_i    (wdt_hit),
    .wake_i       (wake_ev),
    .fall_i       (wake_fall),
    .rd_i         (stat_rd_i),
    .stop_flag_o  (stop_flag),
    .wdt_flag_o   (wdt_flag),
    .resume_irq_o (resume_irq_o)
  );

  always_comb begin
    state_d = state_q;
    if (por_clr || wdt_hit) begin
      state_d = PS_RESET;
    end else begin
      unique case (state_q)
        PS_RESET: if (os_done) state_d = PS_RUN;
        PS_RUN: begin
          if (stop_req_i)      state_d = PS_STOP;
          else if (halt_req_i) state_d = PS_HALT;
        end
        PS_HALT:  if (|irq_i) state_d = PS_RUN;
        PS_STOP:  if (wake_ev) state_d = skip_smr_por_i ? PS_RUN : PS_RESET;
        default:  state_d = PS_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_RESET;
    else         state_q <= state_d;
  end

  assign core_rst_o   = (state_q == PS_RESET);
  assign cpu_clk_en_o = (state_q == PS_RUN);
  assign osc_en_o     = (state_q != PS_STOP);

  always_comb begin
    stat_o                = '0;
    stat_o[STAT_STOP_BIT] = stop_flag;
    stat_o[STAT_WDT_BIT]  = wdt_flag;
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int N_IRQ  = 6,
  parameter int N_WAKE = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_good_i,
  input logic              wdt_timeout_i,
  input logic              halt_req_i,
  input logic              stop_req_i,
  input logic [N_IRQ-1:0]  irq_i,
  input logic [N_WAKE-1:0] fall_i,
  input logic              cpu_clk_en_o,
  input logic              osc_en_o,
  input logic              core_rst_o,
  input logic [7:0]        stat_o
);
  logic quiet;
  assign quiet = pwr_good_i & ~wdt_timeout_i;

  AST_RST_NO_CPU_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> !cpu_clk_en_o); // R1
  AST_PWR_FAIL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> core_rst_o && osc_en_o && stat_o == 8'h00); // R1
  AST_WDT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_good_i && wdt_timeout_i |=> core_rst_o && stat_o[5] && !stat_o[6]); // R3
  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && cpu_clk_en_o && halt_req_i && !stop_req_i |=> !cpu_clk_en_o && osc_en_o); // R4
  AST_HALT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && osc_en_o && !cpu_clk_en_o && !core_rst_o && (|irq_i) |=> cpu_clk_en_o); // R5
  AST_STOP_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !cpu_clk_en_o && !core_rst_o); // R6
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && !osc_en_o && !(|fall_i) |=> !osc_en_o); // R7
  AST_ONESHOT_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && core_rst_o && (stop_req_i || halt_req_i) |=> osc_en_o && !(!core_rst_o && !cpu_clk_en_o)); // R11
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.N_IRQ(N_IRQ), .N_WAKE(N_WAKE)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_good_i    (pwr_good_i),
  .wdt_timeout_i (wdt_timeout_i),
  .halt_req_i    (halt_req_i),
  .stop_req_i    (stop_req_i),
  .irq_i         (irq_i),
  .fall_i        (wake_fall),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .osc_en_o      (osc_en_o),
  .core_rst_o    (core_rst_o),
  .stat_o        (stat_o)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int LIMIT  = 16;
  localparam int NI     = 6;
  localparam int NW     = 11;
  localparam logic [NW-1:0] MASK = 11'h00F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b1, wdt = 1'b0, halt = 1'b0, stop = 1'b0, skip = 1'b0, rd = 1'b0;
  logic [NI-1:0] irq = '0;
  logic [NW-1:0] pins = '1;
  logic cpu_en, osc_en, core_rst, resume;
  logic [7:0] stat;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.POR_CYCLES(LIMIT), .N_IRQ(NI), .N_WAKE(NW), .IRQ_PIN_MASK(MASK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .wdt_timeout_i(wdt),
    .halt_req_i(halt), .stop_req_i(stop), .irq_i(irq), .wake_pin_i(pins),
    .skip_smr_por_i(skip), .stat_rd_i(rd), .cpu_clk_en_o(cpu_en), .osc_en_o(osc_en),
    .core_rst_o(core_rst), .stat_o(stat), .resume_irq_o(resume)
  );

  // Cycle model built from the requirements: 0 reset, 1 run, 2 halt, 3 stop
  int m_st = 0, m_cnt = 0;
  logic [NW-1:0] m_s1 = '1, m_s2 = '1, m_prev = '1;
  logic m_stopf = 0, m_wdtf = 0, m_res = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_s1 = '1; m_s2 = '1; m_prev = '1;
      m_stopf = 0; m_wdtf = 0; m_res = 0;
    end else begin
      logic [NW-1:0] fall;
      fall = m_prev & ~m_s2;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
      if (!pwr_good) begin
        m_st = 0; m_cnt = 0; m_stopf = 0; m_wdtf = 0; m_res = 0;
      end else if (wdt) begin
        m_st = 0; m_cnt = 0; m_stopf = 0; m_wdtf = 1; m_res = 0;
      end else begin
        if (m_st == 3 && |fall) begin
          m_stopf = 1; m_res = |(fall & MASK);
          m_st = skip ? 1 : 0; m_cnt = 0;
        end else begin
          if (rd) m_stopf = 0;
          case (m_st)
            0: if (m_cnt == LIMIT - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
            1: if (stop) m_st = 3; else if (halt) m_st = 2;
            2: if (|irq) m_st = 1;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R2 core_rst_o", core_rst, m_st == 0);
    chk("R4 cpu_clk_en_o", cpu_en, m_st == 1);
    chk("R6 osc_en_o", osc_en, m_st != 3);
    chk("R9 stat_o[6]", stat[6], m_stopf);
    chk("R3 stat_o[5]", stat[5], m_wdtf);
    chk("R10 resume_irq_o", resume, m_res);
    chk("R1 stat_o spare bits", {stat[7], stat[4:0]}, 0);
  end

  task automatic tick(); @(negedge clk); endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    chk("R1 rst core_rst", core_rst, 1); chk("R1 rst cpu", cpu_en, 0);
    chk("R1 rst osc", osc_en, 1); chk("R1 rst stat", stat, 0); chk("R1 rst resume", resume, 0);
    rst_n = 1'b1;
    tick(); stop = 1'b1; halt = 1'b1;  // R11: requests during the one-shot
    tick(); stop = 1'b0; halt = 1'b0;
    repeat (13) tick();
    chk("R2 still in reset", core_rst, 1);
    tick();
    chk("R2 reset released", core_rst, 0);
    chk("R11 request ignored osc", osc_en, 1);
    chk("R11 request ignored cpu", cpu_en, 1);
    // R12: a pin falls outside STOP
    pins[2] = 1'b0; repeat (2) tick(); pins[2] = 1'b1; repeat (4) tick();
    chk("R12 no effect", {cpu_en, osc_en, stat[6]}, 3'b110);
    halt = 1'b1; tick(); halt = 1'b0;
    chk("R4 halt cpu", cpu_en, 0); chk("R4 halt osc", osc_en, 1);
    irq[3] = 1'b1; tick(); irq = '0;
    chk("R5 irq resumes", cpu_en, 1);
    stop = 1'b1; halt = 1'b1; tick(); stop = 1'b0; halt = 1'b0;
    chk("R6 stop osc", osc_en, 0); chk("R6 stop cpu", cpu_en, 0);
    irq = '1; halt = 1'b1; stop = 1'b1; tick(); irq = '0; halt = 1'b0; stop = 1'b0;
    chk("R7 irq ignored in stop", osc_en, 0);
    skip = 1'b0; pins[8] = 1'b0; tick(); tick();
    chk("R7 not yet awake", osc_en, 0);
    tick();
    chk("R8 long path reset", core_rst, 1); chk("R8 osc back", osc_en, 1);
    chk("R9 stop flag set", stat[6], 1); chk("R10 non-irq pin", resume, 0);
    pins[8] = 1'b1;
    repeat (LIMIT - 1) tick();
    chk("R8 one-shot still counting", core_rst, 1);
    tick();
    chk("R8 run after one-shot", cpu_en, 1);
    rd = 1'b1; tick(); rd = 1'b0;
    chk("R9 read clears", stat[6], 0);
    stop = 1'b1; tick(); stop = 1'b0; skip = 1'b1; pins[1] = 1'b0;
    repeat (3) tick();
    chk("R8 skip path cpu", cpu_en, 1); chk("R8 skip path rst", core_rst, 0);
    chk("R10 irq pin", resume, 1); chk("R9 flag on skip", stat[6], 1);
    pins[1] = 1'b1; skip = 1'b0;
    wdt = 1'b1; tick(); wdt = 1'b0;
    chk("R3 wdt reset", core_rst, 1); chk("R3 wdt flag", stat[5], 1);
    chk("R3 stop flag cleared", stat[6], 0); chk("R3 resume cleared", resume, 0);
    pwr_good = 1'b0; tick();
    chk("R1 power fail stat", stat, 0); chk("R1 power fail rst", core_rst, 1);
    pwr_good = 1'b1;
    // random phase, checked by the cycle model
    for (int i = 0; i < 4000; i++) begin
      tick();
      halt = ($urandom_range(19) == 0);
      stop = ($urandom_range(24) == 0);
      irq  = ($urandom_range(14) == 0) ? NI'(1 << $urandom_range(NI - 1)) : '0;
      rd   = ($urandom_range(9) == 0);
      wdt  = ($urandom_range(399) == 0);
      if ($urandom_range(899) == 0) pwr_good = 1'b0;
      else if ($urandom_range(3) == 0) pwr_good = 1'b1;
      if ($urandom_range(5) == 0) pins[$urandom_range(NW - 1)] ^= 1'b1;
      if ($urandom_range(49) == 0) skip = ~skip;
    end
    tick(); halt = 0; stop = 0; irq = '0; rd = 0; wdt = 0; pwr_good = 1;
    repeat (4) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule